// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the processor-facing register file of a 16550-style serial port. A single-cycle synchronous bus reads and writes eight byte-wide registers. The bus address is first scaled down by a power-of-two stride, so the bank can sit on byte, half-word or word spaced address maps. The bank holds these registers:

- interrupt enable
- FIFO control
- line control
- modem control
- a scratch byte
- a 16-bit baud divisor that takes over offsets 0 and 1 while line-control bit 7 is set

The divisor, the raw line-control byte and the loopback mode are driven out to the transmitter and receiver. Bytes written to the data register come out as single-cycle transmit strobes. A byte handed in by the receiver is held until software reads it.

In loopback mode a written data byte goes into the receive holding register, and nothing is sent. The interrupt identification value ranks a received byte above the transmitter-empty condition. The interrupt output is gated by modem-control bit 3.

Top module: `sio_reg_file`

## Requirements
- R1: The register index is bits [STRIDE_SHIFT+2:STRIDE_SHIFT] of `bus_addr`. Address bits below and above that field are ignored (default stride 4, so register k sits at byte address 4*k).
- R2: After reset the divisor is 12, line control reads 0x03, interrupt enable reads 0x00, identification reads 0x01, scratch reads 0x00, and `irq` and `tx_valid` are low.
- R3: While line-control bit 7 is 1, offset 0 reads and writes divisor bits [7:0] instead of the data register, and no byte is transmitted.
- R4: While line-control bit 7 is 1, offset 1 reads and writes divisor bits [15:8], and the interrupt enable register is left untouched.
- R5: A data write with line-control bit 7 clear and loopback off raises `tx_valid` for exactly the cycle after the write, with `tx_byte` equal to the written byte.
- R6: With modem-control bit 4 (loopback) set, a data write loads the receive holding register, and `tx_valid` stays low.
- R7: A `rx_valid` cycle stores `rx_byte` and sets data-ready. A data read returns the held byte and clears data-ready. A data read with nothing held returns 0x00.
- R8: Offset 5 reads 0x60 with bit 0 equal to data-ready. Offset 6 reads 0xB0. Writes to offsets 5 and 6 change neither value.
- R9: Offset 2 reads the identification value: 0x04 when enable bit 0 is set and a byte is held, else 0x02 when enable bit 1 is set and the transmitter-empty flag is set, else 0x01. Bits 7:6 read 11 when bit 0 of the last offset-2 write was 1.
- R10: The transmitter-empty flag is set by a data write to the data register (loopback or not) and by an interrupt-enable write that turns bit 1 from 0 to 1. It is cleared by an offset-2 read that returns identification 0x02.
- R11: `irq` is high when the identification value is not 0x01 and modem-control bit 3 is set.
- R12: Offset 7 returns the last byte written to it.
- R13: `bus_rdata` is registered. It shows the read value in the cycle after the read and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address, scaled by the stride |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_valid | output | 1 | One-cycle strobe of a byte to send |
| tx_byte | output | 8 | Byte to send |
| rx_valid | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line-control byte (word length, stop, parity, break, divisor access) |
| loopback | output | 1 | Loopback mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following properties:

- Every transmit strobe traces back to a data write made one cycle earlier, with the same byte.
- No strobe appears while loopback is on.
- The divisor changes only after a divisor-access write.
- The line and modem status reads have their fixed shape.
- Read data stays unchanged between reads.

Only the scenarios can show the value-level behaviour. This covers the divisor aliasing round trip, the rx-over-tx identification priority, the flag being cleared by an identification read, the loopback byte being read back, and status writes being ignored.

// File: rtl/sio_reg_file.sv
module sio_reg_file #(
  parameter int ADDR_W       = 8,
  parameter int STRIDE_SHIFT = 2,
  parameter logic [15:0] DIV_RESET = 16'd12,
  parameter logic [7:0]  LCR_RESET = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [15:0]       divisor,
  output logic [7:0]        line_ctrl,
  output logic              loopback,
  output logic              irq
);
  localparam int IDX_W = 3;

  logic [IDX_W-1:0] idx;
  logic [3:0] ier;
  logic [4:0] mcr;
  logic [7:0] scratch, hold;
  logic       fifo_on, rx_ready, thre;
  logic       rd_en, wr_en, dlab, rx_int, tx_int;
  logic [3:0] iir_id;
  logic [7:0] iir, lsr, rd_mux;

  assign idx    = bus_addr[STRIDE_SHIFT +: IDX_W];
  assign rd_en  = bus_sel && !bus_wr;
  assign wr_en  = bus_sel && bus_wr;
  assign dlab   = line_ctrl[7];
  assign rx_int = ier[0] && rx_ready;
  assign tx_int = ier[1] && thre;
  assign iir_id = rx_int ? 4'h4 : (tx_int ? 4'h2 : 4'h1);
  assign iir    = {{2{fifo_on}}, 2'b00, iir_id};
  assign lsr    = {1'b0, 1'b1, 1'b1, 4'b0000, rx_ready};
  assign loopback = mcr[4];
  assign irq    = (rx_int || tx_int) && mcr[3];

  always_comb begin
    case (idx)
      3'd0:    rd_mux = dlab ? divisor[7:0] : (rx_ready ? hold : 8'h00);
      3'd1:    rd_mux = dlab ? divisor[15:8] : {4'h0, ier};
      3'd2:    rd_mux = iir;
      3'd3:    rd_mux = line_ctrl;
      3'd4:    rd_mux = {3'b000, mcr};
      3'd5:    rd_mux = lsr;
      3'd6:    rd_mux = 8'hB0;
      default: rd_mux = scratch;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor   <= DIV_RESET;
      line_ctrl <= LCR_RESET;
      ier       <= '0;
      mcr       <= '0;
      scratch   <= '0;
      hold      <= '0;
      fifo_on   <= 1'b0;
      rx_ready  <= 1'b0;
      thre      <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      bus_rdata <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (rd_en) begin
        bus_rdata <= rd_mux;
        if (idx == 3'd0 && !dlab) rx_ready <= 1'b0;
        if (idx == 3'd2 && !rx_int && tx_int) thre <= 1'b0;
      end
      if (wr_en) begin
        case (idx)
          3'd0: begin
            if (dlab) divisor[7:0] <= bus_wdata;
            else begin
              thre <= 1'b1;
              if (loopback) begin
                hold     <= bus_wdata;
                rx_ready <= 1'b1;
              end else begin
                tx_valid <= 1'b1;
                tx_byte  <= bus_wdata;
              end
            end
          end
          3'd1: begin
            if (dlab) divisor[15:8] <= bus_wdata;
            else begin
              if (!ier[1] && bus_wdata[1]) thre <= 1'b1;
              ier <= bus_wdata[3:0];
            end
          end
          3'd2: fifo_on   <= bus_wdata[0];
          3'd3: line_ctrl <= bus_wdata;
          3'd4: mcr       <= bus_wdata[4:0];
          3'd7: scratch   <= bus_wdata;
          default: ;
        endcase
      end
      if (rx_valid) begin
        hold     <= rx_byte;
        rx_ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_reg_file_chk.sv
module sio_reg_file_chk #(
  parameter int ADDR_W       = 8,
  parameter int STRIDE_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic [15:0]       divisor,
  input logic [7:0]        line_ctrl,
  input logic              loopback
);
  logic [2:0] cidx;
  assign cidx = bus_addr[STRIDE_SHIFT +: 3];

  assert_tx_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(bus_sel && bus_wr && cidx == 3'd0) && tx_byte == $past(bus_wdata)));

  assert_no_tx_in_loopback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !$past(loopback));

  assert_divisor_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor) |-> $past(bus_sel && bus_wr && line_ctrl[7] && cidx <= 3'd1));

  assert_lsr_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && cidx == 3'd5) |=> (bus_rdata[7:1] == 7'h30));

  assert_msr_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && cidx == 3'd6) |=> (bus_rdata == 8'hB0));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind sio_reg_file sio_reg_file_chk #(.ADDR_W(ADDR_W), .STRIDE_SHIFT(STRIDE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .divisor(divisor), .line_ctrl(line_ctrl), .loopback(loopback)
);

// File: tb/sio_reg_file_tb.sv
module sio_reg_file_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic tx_valid, rx_valid = 1'b0, loopback, irq;
  logic [7:0] tx_byte, rx_byte = '0, line_ctrl;
  logic [15:0] divisor;

  sio_reg_file u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .divisor(divisor), .line_ctrl(line_ctrl),
    .loopback(loopback), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t rdq[$];
  exp_t txq[$];
  int vectors = 0, miscompares = 0;
  logic pend = 1'b0;
  exp_t e;
  bit done = 0;

  task automatic compare(input string tag, input logic [15:0] act, input logic [15:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        if (rdq.size() == 0) compare("R13 unexpected read", 16'h0, 16'h1);
        else begin
          e = rdq.pop_front();
          compare(e.tag, {8'h0, bus_rdata}, {8'h0, e.v});
        end
      end
      pend = bus_sel && !bus_wr;
      if (tx_valid) begin
        if (txq.size() == 0) compare("R5/R6 unexpected tx", {8'h0, tx_byte}, 16'hFFFF);
        else begin
          e = txq.pop_front();
          compare(e.tag, {8'h0, tx_byte}, {8'h0, e.v});
        end
      end
    end
  end

  task automatic wr(input logic [2:0] r, input logic [7:0] d, input logic [1:0] lo = 2'b00);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {3'b000, r, lo}; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r, input logic [7:0] expv, input string tag,
                    input logic [1:0] lo = 2'b00, input logic [2:0] hi = 3'b000);
    exp_t x;
    x.v = expv; x.tag = tag;
    rdq.push_back(x);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {hi, r, lo};
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic expect_tx(input logic [7:0] b, input string tag);
    exp_t x;
    x.v = b; x.tag = tag;
    txq.push_back(x);
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    compare("R2 divisor reset", divisor, 16'd12);
    compare("R2 irq reset", {15'h0, irq}, 16'h0);
    compare("R2 tx_valid reset", {15'h0, tx_valid}, 16'h0);
    rd(3, 8'h03, "R2 line control reset");
    rd(2, 8'h01, "R2 identification reset");
    rd(1, 8'h00, "R2 enable reset");
    rd(7, 8'h00, "R2 scratch reset");
    rd(5, 8'h60, "R8 line status idle");
    rd(6, 8'hB0, "R8 modem status");

    wr(3, 8'h83);
    rd(0, 8'h0C, "R3 divisor low read");
    rd(1, 8'h00, "R4 divisor high read");
    wr(0, 8'h34);
    wr(1, 8'h12);
    compare("R3 R4 divisor port", divisor, 16'h1234);
    rd(0, 8'h34, "R3 divisor low readback");
    rd(1, 8'h12, "R4 divisor high readback");
    wr(3, 8'h1B);
    compare("R3 line_ctrl port", {8'h0, line_ctrl}, 16'h001B);
    rd(1, 8'h00, "R4 enable untouched by divisor write");

    expect_tx(8'h55, "R5 tx byte 1");
    wr(0, 8'h55);
    expect_tx(8'hA0, "R5 tx byte 2");
    wr(0, 8'hA0);
    rd(2, 8'h01, "R9 ungated flag not reported");

    wr(1, 8'h02);
    compare("R11 irq gated by mcr", {15'h0, irq}, 16'h0);
    rd(2, 8'h02, "R10 flag reported");
    rd(2, 8'h01, "R10 flag cleared by read");
    wr(4, 8'h08);
    expect_tx(8'h11, "R5 tx byte 3");
    wr(0, 8'h11);
    compare("R11 irq on tx empty", {15'h0, irq}, 16'h1);
    rd(2, 8'h02, "R10 flag after data write");
    compare("R11 irq cleared", {15'h0, irq}, 16'h0);

    push_rx(8'h5A);
    rd(5, 8'h61, "R7 data ready in status");
    wr(1, 8'h03);
    compare("R11 irq on rx", {15'h0, irq}, 16'h1);
    rd(2, 8'h04, "R9 rx identification");
    rd(0, 8'h5A, "R7 received byte");
    rd(5, 8'h60, "R7 ready cleared");
    rd(0, 8'h00, "R7 empty read");
    compare("R11 irq idle", {15'h0, irq}, 16'h0);

    expect_tx(8'h22, "R5 tx byte 4");
    wr(0, 8'h22);
    push_rx(8'h33);
    rd(2, 8'h04, "R9 rx has priority");
    rd(0, 8'h33, "R7 second byte");
    rd(2, 8'h02, "R9 tx after rx");
    rd(2, 8'h01, "R9 none pending");

    wr(4, 8'h18);
    compare("R6 loopback port", {15'h0, loopback}, 16'h1);
    wr(0, 8'h77);
    rd(5, 8'h61, "R6 loopback byte held");
    rd(0, 8'h77, "R6 loopback byte read");
    rd(2, 8'h02, "R10 loopback write sets flag");

    wr(5, 8'h00);
    rd(5, 8'h60, "R8 status write ignored");
    wr(6, 8'h00);
    rd(6, 8'hB0, "R8 modem write ignored");

    wr(2, 8'h01);
    rd(2, 8'hC1, "R9 fifo bits");

    wr(7, 8'hA5, 2'b10);
    rd(7, 8'hA5, "R12 R1 scratch low bits ignored", 2'b01, 3'b101);
    held = bus_rdata;
    repeat (3) @(posedge clk);
    #1 compare("R13 rdata holds", {8'h0, bus_rdata}, {8'h0, held});

    repeat (3) @(posedge clk);
    compare("R5 tx queue drained", 16'(txq.size()), 16'h0);
    compare("R13 read queue drained", 16'(rdq.size()), 16'h0);
    finish_run();
  end
endmodule